// File: doc/BRIEF.md
# Parallel Printer Port Controller

This block is a peripheral in a port-mapped I/O space. It passes bytes from a host to a line printer over an 8-bit parallel data path plus a strobe line. The host bus has a 10-bit address, an I/O-space qualifier, read and write strobes, and byte-wide data. Only three consecutive port addresses are decoded. The data port holds the byte on the printer lines. The status port reports printer readiness and the acknowledge level. The control port drives the strobe.

In the normal flow, software performs the handshake itself. It polls status until the ready bit is 1, writes the byte, writes 0x01 to control and then writes 0x00 to control. When the autonomous bit in control is set, one write to the data port starts the whole handshake. The block waits for the printer to be free, holds the data for a setup clock, and then pulses the strobe for a fixed number of clocks.

Top module: `prn_port`

## Requirements
- R1: Ports are decoded only when the I/O qualifier is high. The data port is at BASE_ADDR (default 0x378), status at BASE_ADDR+1 and control at BASE_ADDR+2, on a 10-bit address.
- R2: A data-port write latches the byte on the rising clock edge of the write. The byte appears on the printer data lines and stays there until the next accepted data write. Reading the data port returns that byte.
- R3: Status bit 7 reads 1 when the printer is free and no autonomous transfer is active. Status bit 6 reads the synchronized acknowledge level. Status bits 5..0 read 0.
- R4: The busy and acknowledge inputs each pass through two flops. A level change shows in status after the second rising edge, and not after the first.
- R5: Reading the control port returns the last byte written to it. Control bit 0 drives the strobe line directly from the edge that writes it.
- R6: With control bit 4 set, a data-port write starts a transfer. The strobe rises no earlier than one clock after the data lines change, and status bit 7 reads 0 until the transfer ends.
- R7: An autonomous strobe stays high for exactly PULSE_CYCLES clocks (default 3), then falls. Status bit 7 returns to 1 when the strobe falls.
- R8: A transfer whose byte arrives while the printer is busy holds the strobe low until the synchronized busy input clears.
- R9: A data-port write made while an autonomous transfer is active is ignored.
- R10: Reads outside the three ports, or without the I/O qualifier, return 0xFF. Such writes, and any write to the status port, change nothing.
- R11: After reset the data lines, the control register and the strobe are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 10 | I/O port address |
| busIoSel | input | 1 | High for I/O-space cycles |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational |
| prnData | output | 8 | Printer data lines |
| prnStrobe | output | 1 | Printer strobe, active high |
| prnBusy | input | 1 | Printer busy, active high, asynchronous |
| prnAck | input | 1 | Printer acknowledge, asynchronous |

## Verification
A wrong address decode or a stray write shows on the printer data lines one clock later, or in the 0xFF read value at once. A synchronizer of the wrong depth moves the status bit change by one edge, so the bench samples after the first and after the second edge. A bad pulse counter or setup state changes the strobe length, or the clock in which the strobe rises relative to the data write. Both are measured cycle by cycle on the strobe pin.

// File: rtl/prn_pkg.sv
package prn_pkg;
  typedef enum logic [1:0] {RD_NONE, RD_DATA, RD_STAT, RD_CTRL} rdSel_e;

  typedef struct packed {
    logic   wrData;
    logic   wrCtrl;
    rdSel_e rdSel;
    logic   autoStrobe;
    logic   autoActive;
  } dpCmd_t;

  localparam int CTRL_STROBE_BIT = 0;
  localparam int CTRL_AUTO_BIT   = 4;
  localparam int STAT_ACK_BIT    = 6;
  localparam int STAT_READY_BIT  = 7;
endpackage

// File: rtl/prn_ctrl.sv
module prn_ctrl
  import prn_pkg::*;
#(
  parameter int          ADDR_W       = 10,
  parameter logic [9:0]  BASE_ADDR    = 10'h378,
  parameter int          PULSE_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busIoSel,
  input  logic              busRd,
  input  logic              busWr,
  input  logic              autoEn,
  input  logic              busySync,
  output dpCmd_t            cmd
);
  localparam int CW = $clog2(PULSE_CYCLES + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_STROBE} aState_e;

  aState_e        state;
  logic [CW-1:0]  pulseCnt;
  logic           hitData, hitStat, hitCtrl;
  logic           active;

  assign hitData = busIoSel && (busAddr == ADDR_W'(BASE_ADDR));
  assign hitStat = busIoSel && (busAddr == ADDR_W'(BASE_ADDR + 10'd1));
  assign hitCtrl = busIoSel && (busAddr == ADDR_W'(BASE_ADDR + 10'd2));
  assign active  = (state != ST_IDLE);

  always_comb begin
    cmd            = '0;
    cmd.wrData     = busWr && hitData && !(autoEn && active);
    cmd.wrCtrl     = busWr && hitCtrl;
    cmd.autoStrobe = (state == ST_STROBE);
    cmd.autoActive = active;
    if (!busRd)       cmd.rdSel = RD_NONE;
    else if (hitData) cmd.rdSel = RD_DATA;
    else if (hitStat) cmd.rdSel = RD_STAT;
    else if (hitCtrl) cmd.rdSel = RD_CTRL;
    else              cmd.rdSel = RD_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      pulseCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (cmd.wrData && autoEn) state <= ST_SETUP;
        ST_SETUP: if (!busySync) begin
          state    <= ST_STROBE;
          pulseCnt <= CW'(PULSE_CYCLES - 1);
        end
        ST_STROBE: begin
          if (pulseCnt == '0) state <= ST_IDLE;
          else                pulseCnt <= pulseCnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // independent pulse-length observer for the assertions
  logic [15:0] chkLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               chkLen <= '0;
    else if (cmd.autoStrobe) chkLen <= chkLen + 16'd1;
    else                     chkLen <= '0;
  end

  AST_PULSE_NOT_LONG: assert property (@(posedge clk) disable iff (!rstN)
    cmd.autoStrobe |-> chkLen < 16'(PULSE_CYCLES)); // R7
  AST_PULSE_FULL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cmd.autoStrobe) |-> chkLen == 16'(PULSE_CYCLES)); // R7
  AST_WAIT_READY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmd.autoStrobe) |-> !$past(busySync)); // R8
  AST_NO_WR_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    (autoEn && active) |-> !cmd.wrData); // R9
endmodule

// File: rtl/prn_datapath.sv
module prn_datapath
  import prn_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              prnBusy,
  input  logic              prnAck,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] prnData,
  output logic              prnStrobe,
  output logic              autoEn,
  output logic              busySync
);
  logic [DATA_W-1:0]   dataReg, ctrlReg, statusVal;
  logic [SYNC_STG-1:0] busyPipe, ackPipe;
  logic                ackSync, statusReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
      ctrlReg <= '0;
    end else begin
      if (cmd.wrData) dataReg <= busWdata;
      if (cmd.wrCtrl) ctrlReg <= busWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyPipe <= '0;
      ackPipe  <= '0;
    end else begin
      busyPipe <= {busyPipe[SYNC_STG-2:0], prnBusy};
      ackPipe  <= {ackPipe[SYNC_STG-2:0], prnAck};
    end
  end

  assign busySync    = busyPipe[SYNC_STG-1];
  assign ackSync     = ackPipe[SYNC_STG-1];
  assign statusReady = !busySync && !cmd.autoActive;
  assign autoEn      = ctrlReg[CTRL_AUTO_BIT];

  always_comb begin
    statusVal                 = '0;
    statusVal[STAT_READY_BIT] = statusReady;
    statusVal[STAT_ACK_BIT]   = ackSync;
  end

  always_comb begin
    unique case (cmd.rdSel)
      RD_DATA: busRdata = dataReg;
      RD_STAT: busRdata = statusVal;
      RD_CTRL: busRdata = ctrlReg;
      default: busRdata = '1;
    endcase
  end

  assign prnData   = dataReg;
  assign prnStrobe = ctrlReg[CTRL_STROBE_BIT] | cmd.autoStrobe;

  logic [1:0] rstAge;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rstAge <= '0;
    else if (rstAge != 2'd3) rstAge <= rstAge + 2'd1;
  end

  AST_BUSY_BLOCKS_READY: assert property (@(posedge clk) disable iff (!rstN)
    (rstAge == 2'd3 && $past(prnBusy) && $past(prnBusy, 2)) |-> !statusReady); // R4
  AST_DATA_SETUP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmd.autoStrobe) |-> $stable(prnData)); // R6
  AST_CTRL_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    $past(cmd.wrCtrl) |-> ctrlReg == $past(busWdata)); // R5
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(cmd.wrData) |-> $stable(prnData)); // R2
endmodule

// File: rtl/prn_port.sv
module prn_port
  import prn_pkg::*;
#(
  parameter int         ADDR_W       = 10,
  parameter int         DATA_W       = 8,
  parameter logic [9:0] BASE_ADDR    = 10'h378,
  parameter int         PULSE_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busIoSel,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] prnData,
  output logic              prnStrobe,
  input  logic              prnBusy,
  input  logic              prnAck
);
  dpCmd_t cmd;
  logic   autoEn, busySync;

  prn_ctrl #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .PULSE_CYCLES(PULSE_CYCLES)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busIoSel(busIoSel),
    .busRd(busRd), .busWr(busWr), .autoEn(autoEn), .busySync(busySync),
    .cmd(cmd)
  );

  prn_datapath #(.DATA_W(DATA_W), .SYNC_STG(2)) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .busWdata(busWdata),
    .prnBusy(prnBusy), .prnAck(prnAck), .busRdata(busRdata),
    .prnData(prnData), .prnStrobe(prnStrobe), .autoEn(autoEn),
    .busySync(busySync)
  );

  AST_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !(busIoSel && busAddr == ADDR_W'(BASE_ADDR))) |=> $stable(prnData)); // R10
endmodule

// File: tb/prn_port_tb.sv
module prn_port_tb_top;
  localparam logic [9:0] BASE  = 10'h378;
  localparam int         PULSE = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [9:0] busAddr = '0;
  logic       busIoSel = 1'b0, busRd = 1'b0, busWr = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata, prnData;
  logic       prnStrobe;
  logic       prnBusy = 1'b0, prnAck = 1'b0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  prn_port #(.BASE_ADDR(BASE), .PULSE_CYCLES(PULSE)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busIoSel(busIoSel),
    .busRd(busRd), .busWr(busWr), .busWdata(busWdata), .busRdata(busRdata),
    .prnData(prnData), .prnStrobe(prnStrobe), .prnBusy(prnBusy), .prnAck(prnAck)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [9:0] a, input logic [7:0] d, input bit io = 1'b1);
    @(negedge clk);
    busAddr = a; busIoSel = io; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0; busIoSel = 1'b0;
  endtask

  task automatic busRead(input logic [9:0] a, output logic [7:0] d, input bit io = 1'b1);
    @(negedge clk);
    busAddr = a; busIoSel = io; busRd = 1'b1;
    #2 d = busRdata;
    busRd = 1'b0; busIoSel = 1'b0;
  endtask

  task automatic testReset();
    logic [7:0] v;
    check(prnData == 8'h00, "R11 data", prnData, 0);
    check(prnStrobe == 1'b0, "R11 strobe", prnStrobe, 0);
    busRead(BASE + 10'd2, v);
    check(v == 8'h00, "R11 ctrl", v, 0);
    busRead(BASE + 10'd1, v);
    check(v == 8'h80, "R3 status idle", v, 8'h80);
  endtask

  task automatic testDataPort();
    logic [7:0] v;
    busWrite(BASE, 8'h5A);
    check(prnData == 8'h5A, "R2 lines", prnData, 8'h5A);
    busRead(BASE, v);
    check(v == 8'h5A, "R2 readback", v, 8'h5A);
    repeat (3) @(negedge clk);
    check(prnData == 8'h5A, "R2 hold", prnData, 8'h5A);
    check(prnStrobe == 1'b0, "R5 no strobe in manual mode", prnStrobe, 0);
  endtask

  task automatic testDecode();
    logic [7:0] v;
    busWrite(BASE, 8'hC3, 1'b0);
    check(prnData == 8'h5A, "R10 write without qualifier", prnData, 8'h5A);
    busWrite(BASE + 10'd3, 8'h11);
    check(prnData == 8'h5A, "R10 write off-port", prnData, 8'h5A);
    busWrite(BASE + 10'd1, 8'h3F);
    busRead(BASE + 10'd1, v);
    check(v == 8'h80, "R10 status write ignored", v, 8'h80);
    busRead(BASE, v, 1'b0);
    check(v == 8'hFF, "R10 read without qualifier", v, 8'hFF);
    busRead(BASE - 10'd1, v);
    check(v == 8'hFF, "R1 read below base", v, 8'hFF);
    busRead(10'h078, v);
    check(v == 8'hFF, "R1 alias address", v, 8'hFF);
  endtask

  task automatic testSync();
    logic [7:0] v;
    @(negedge clk);
    prnBusy = 1'b1; prnAck = 1'b1;
    @(negedge clk);
    busAddr = BASE + 10'd1; busIoSel = 1'b1; busRd = 1'b1;
    #2 check(busRdata == 8'h80, "R4 one edge", busRdata, 8'h80);
    @(negedge clk);
    #2 check(busRdata == 8'h40, "R4 two edges busy+ack", busRdata, 8'h40);
    busRd = 1'b0; busIoSel = 1'b0;
    prnBusy = 1'b0; prnAck = 1'b0;
    repeat (2) @(negedge clk);
    busRead(BASE + 10'd1, v);
    check(v == 8'h80, "R3 ready again", v, 8'h80);
  endtask

  task automatic testManualStrobe();
    logic [7:0] v;
    busWrite(BASE + 10'd2, 8'h01);
    check(prnStrobe == 1'b1, "R5 strobe high", prnStrobe, 1);
    busRead(BASE + 10'd2, v);
    check(v == 8'h01, "R5 ctrl readback", v, 1);
    busWrite(BASE + 10'd2, 8'hA0);
    check(prnStrobe == 1'b0, "R5 strobe low", prnStrobe, 0);
    busRead(BASE + 10'd2, v);
    check(v == 8'hA0, "R5 full byte readback", v, 8'hA0);
    busWrite(BASE + 10'd2, 8'h00);
  endtask

  task automatic measurePulse(input string req);
    int hi = 0;
    while (prnStrobe && hi < 50) begin
      hi++;
      @(negedge clk);
    end
    check(hi == PULSE, req, hi, PULSE);
  endtask

  task automatic testAutoBasic();
    logic [7:0] v;
    busWrite(BASE + 10'd2, 8'h10);
    busWrite(BASE, 8'hA5);
    check(prnData == 8'hA5 && prnStrobe == 1'b0, "R6 setup clock", prnStrobe, 0);
    #2 busAddr = BASE + 10'd1; busIoSel = 1'b1; busRd = 1'b1;
    #1 check(busRdata[7] == 1'b0, "R6 not ready during transfer", busRdata, 0);
    busRd = 1'b0; busIoSel = 1'b0;
    @(negedge clk);
    check(prnStrobe == 1'b1, "R6 strobe rises", prnStrobe, 1);
    measurePulse("R7 pulse width");
    busRead(BASE + 10'd1, v);
    check(v == 8'h80, "R7 ready after pulse", v, 8'h80);
  endtask

  task automatic testAutoIgnore();
    logic [7:0] v;
    busWrite(BASE, 8'h66);
    busWrite(BASE, 8'h3C);
    check(prnData == 8'h66, "R9 write during transfer", prnData, 8'h66);
    while (prnStrobe) @(negedge clk);
    busRead(BASE, v);
    check(v == 8'h66, "R9 data reg kept", v, 8'h66);
  endtask

  task automatic testAutoBusy();
    @(negedge clk);
    prnBusy = 1'b1;
    repeat (3) @(negedge clk);
    busWrite(BASE, 8'h77);
    repeat (4) @(negedge clk);
    check(prnStrobe == 1'b0 && prnData == 8'h77, "R8 held while busy", prnStrobe, 0);
    prnBusy = 1'b0;
    repeat (2) @(negedge clk);
    check(prnStrobe == 1'b0, "R8 waits for sync", prnStrobe, 0);
    @(negedge clk);
    check(prnStrobe == 1'b1, "R8 strobe after busy clears", prnStrobe, 1);
    measurePulse("R7 pulse width after wait");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDataPort();
    testDecode();
    testSync();
    testManualStrobe();
    testAutoBasic();
    testAutoIgnore();
    testAutoBusy();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule